// File: doc/BRIEF.md
# Mode-Aware Bidirectional GPIO Port

This block controls an 8-bit general-purpose I/O port behind a small register bus with 16-bit addresses and byte-wide accesses. Four registers sit behind the bus: a pin direction register that can be written but not read, an output latch, a pull-up enable register, and a read-only view of the pin levels. The block drives a per-pin output enable, a per-pin output value and a per-pin pull-up enable toward the pad ring. The pads themselves are outside the block.

An operating-mode input decides who owns the pins. In modes 3 and 7 the port belongs to software, and the direction register chooses input or output for each pin. In every other mode the pins serve an external data bus. The block then releases its drivers, turns all pull-ups off, ignores the direction register and raises a select line toward the bus logic.

Two kinds of reset are handled. Power-on reset and hardware standby clear all three writable registers. A manual reset and software standby leave the registers untouched and block writes while they are active.

Top module: `gpio_mode_port`

## Requirements
- R1: After power-on reset (por_n low), the direction, output latch and pull-up registers are 0x00. pin_oe and pin_pu are then 0x00, and reads of the latch and pull-up addresses return 0x00.
- R2: While hw_stby is high, the direction, latch and pull-up registers are held at 0x00. This takes effect without waiting for a clock edge, and they read 0x00 after hw_stby falls.
- R3: While man_rst_n is low or sw_stby is high, bus writes are ignored and all three writable registers keep their contents. When the condition ends, the old values are still in place.
- R4: The register map, with reads combinational while bus_rd is high:
  - 0xFF6C is the output latch (read/write).
  - 0xFF73 is the pull-up register (read/write).
  - 0xFF5C is the pin view (read-only).
  - 0xFEBC is the direction register (write-only; its read value is undefined).
  - Any other address reads 0x00 and ignores writes, and bus_rdata is 0x00 whenever bus_rd is low.
- R5: In port mode (mode equal to 3 or 7), pin_oe equals the direction register, with bit i = 1 meaning pin i is an output. pin_out carries the latch bits for output pins and 0 for input pins, and bus_sel is 0.
- R6: In any other mode (bus mode), pin_oe = 0x00, pin_out = 0x00, pin_pu = 0x00 and bus_sel = 1, whatever the direction register holds.
- R7: pin_pu bit i is 1 only when the port is in port mode, direction bit i is 0, and pull-up bit i is 1.
- R8: The pin view returns the latch bit for output pins. For input pins, and for every pin in bus mode, it returns pin_in passed through two clock stages. A change of pin_in therefore shows on a read after the second rising edge, and not after the first.
- R9: A write takes effect at the rising edge where bus_wr is high and is visible from then on. A write to the pin-view address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_stby | input | 1 | Hardware standby, active high; clears the registers |
| man_rst_n | input | 1 | Manual reset, active low; registers retained, writes blocked |
| sw_stby | input | 1 | Software standby, active high; registers retained, writes blocked |
| mode | input | 3 | Operating mode; 3 and 7 select port mode |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |
| bus_sel | output | 1 | Pins handed to the external data bus |

## Verification
A direction register that is wrong shows on pin_oe in the same cycle, and a wrong latch shows on pin_out. A wrong pull-up register shows on pin_pu, but only for pins that are inputs in port mode, so the bench sets up mixed directions to expose it. A synchroniser that is too short or too long shows as a pin-view read one cycle early or late, so the bench samples after exactly one and two edges. A retention fault under manual reset, software standby or bus mode stays hidden until the condition ends, so the bench reads the registers back immediately afterwards.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_DIR  = 3'd1,
      SEL_DATA = 3'd2,
      SEL_PIN  = 3'd3,
      SEL_PULL = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_port_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] OFS_DIR  = 16'hFEBC,
   parameter logic [15:0] OFS_DATA = 16'hFF6C,
   parameter logic [15:0] OFS_PIN  = 16'hFF5C,
   parameter logic [15:0] OFS_PULL = 16'hFF73
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(OFS_PIN);
   localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(OFS_PULL);

   always_comb begin
      sel = SEL_NONE;
      if      (addr == A_DIR)  sel = SEL_DIR;
      else if (addr == A_DATA) sel = SEL_DATA;
      else if (addr == A_PIN)  sel = SEL_PIN;
      else if (addr == A_PULL) sel = SEL_PULL;
   end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             por_n,
   input  logic             hold,
   input  logic             wr,
   input  reg_sel_e         sel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] dat_q,
   output logic [WIDTH-1:0] pull_q
);
   logic wr_ok;
   assign wr_ok = wr & ~hold;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         dir_q  <= '0;
         dat_q  <= '0;
         pull_q <= '0;
      end else if (wr_ok) begin
         case (sel)
            SEL_DIR:  dir_q  <= wdata;
            SEL_DATA: dat_q  <= wdata;
            SEL_PULL: pull_q <= wdata;
            default:  ;
         endcase
      end
   end

   // R2
   hw_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      !clr_n |-> (dir_q == '0 && dat_q == '0 && pull_q == '0));

   // R3
   hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
      hold |=> ($stable(dir_q) && $stable(dat_q) && $stable(pull_q)));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
   parameter int WIDTH  = 8,
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [MODE_W-1:0] mode,
   input  logic [WIDTH-1:0]  dir_q,
   input  logic [WIDTH-1:0]  dat_q,
   input  logic [WIDTH-1:0]  pull_q,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_pu,
   output logic [WIDTH-1:0]  pin_view,
   output logic              bus_sel
);
   localparam logic [MODE_W-1:0] PORT_MODE_A = MODE_W'(3);
   localparam logic [MODE_W-1:0] PORT_MODE_B = MODE_W'(7);

   logic             port_mode;
   logic [WIDTH-1:0] dir_eff;

   assign port_mode = (mode == PORT_MODE_A) || (mode == PORT_MODE_B);
   assign dir_eff   = port_mode ? dir_q : '0;
   assign bus_sel   = ~port_mode;
   assign pin_oe    = dir_eff;
   assign pin_out   = dat_q & dir_eff;
   assign pin_pu    = port_mode ? (pull_q & ~dir_q) : '0;
   assign pin_view  = (dat_q & dir_eff) | (pin_sync & ~dir_eff);

   // R6
   bus_release_chk: assert property (@(posedge clk) disable iff (!por_n)
      bus_sel |-> (pin_oe == '0 && pin_pu == '0 && pin_out == '0));

   // R7
   pu_input_only_chk: assert property (@(posedge clk) disable iff (!por_n)
      (pin_pu & pin_oe) == '0);

   // R5
   out_needs_oe_chk: assert property (@(posedge clk) disable iff (!por_n)
      (pin_out & ~pin_oe) == '0);
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
   import gpio_port_pkg::*;
#(
   parameter int          WIDTH       = 8,
   parameter int          ADDR_W      = 16,
   parameter int          MODE_W      = 3,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] OFS_DIR     = 16'hFEBC,
   parameter logic [15:0] OFS_DATA    = 16'hFF6C,
   parameter logic [15:0] OFS_PIN     = 16'hFF5C,
   parameter logic [15:0] OFS_PULL    = 16'hFF73,
   parameter logic [7:0]  DIR_RD_FILL = 8'h5A
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hw_stby,
   input  logic              man_rst_n,
   input  logic              sw_stby,
   input  logic [MODE_W-1:0] mode,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_pu,
   output logic              bus_sel
);
   localparam logic [WIDTH-1:0] DIR_FILL = WIDTH'(DIR_RD_FILL);

   if (WIDTH < 1)       begin : g_bad_w   $error("WIDTH must be positive");   end
   if (ADDR_W > 16)     begin : g_bad_a   $error("ADDR_W above 16");           end
   if (SYNC_STAGES < 2) begin : g_bad_s   $error("SYNC_STAGES below 2");       end
   if (MODE_W < 3)      begin : g_bad_m   $error("MODE_W below 3");            end
   if (OFS_DIR == OFS_DATA || OFS_DIR == OFS_PIN || OFS_DIR == OFS_PULL ||
       OFS_DATA == OFS_PIN || OFS_DATA == OFS_PULL || OFS_PIN == OFS_PULL)
   begin : g_bad_ofs $error("register offsets overlap"); end

   logic             clr_n, sync_rst_n, hold;
   reg_sel_e         sel;
   logic [WIDTH-1:0] dir_q, dat_q, pull_q, pin_sync, pin_view;

   assign clr_n      = por_n & ~hw_stby;
   assign sync_rst_n = clr_n & man_rst_n;
   assign hold       = ~man_rst_n | sw_stby;

   gpio_addr_dec #(
      .ADDR_W(ADDR_W), .OFS_DIR(OFS_DIR), .OFS_DATA(OFS_DATA),
      .OFS_PIN(OFS_PIN), .OFS_PULL(OFS_PULL)
   ) u_dec (
      .addr(bus_addr), .sel(sel)
   );

   gpio_regbank #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .clr_n(clr_n), .por_n(por_n), .hold(hold), .wr(bus_wr),
      .sel(sel), .wdata(bus_wdata),
      .dir_q(dir_q), .dat_q(dat_q), .pull_q(pull_q)
   );

   gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(sync_rst_n), .d(pin_in), .q(pin_sync)
   );

   gpio_pad_ctrl #(.WIDTH(WIDTH), .MODE_W(MODE_W)) u_pad (
      .clk(clk), .por_n(por_n), .mode(mode),
      .dir_q(dir_q), .dat_q(dat_q), .pull_q(pull_q), .pin_sync(pin_sync),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
      .pin_view(pin_view), .bus_sel(bus_sel)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (sel)
            SEL_DIR:  bus_rdata = DIR_FILL;
            SEL_DATA: bus_rdata = dat_q;
            SEL_PIN:  bus_rdata = pin_view;
            SEL_PULL: bus_rdata = pull_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   // R4
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      !bus_rd |-> bus_rdata == '0);

   // R9
   wr_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (bus_wr && !hold && bus_addr == ADDR_W'(OFS_DATA)) |=> dat_q == $past(bus_wdata));
endmodule

// File: tb/tb_gpio_mode_port.sv
module tb_gpio_mode_port;
   localparam logic [15:0] A_DIR  = 16'hFEBC;
   localparam logic [15:0] A_DATA = 16'hFF6C;
   localparam logic [15:0] A_PIN  = 16'hFF5C;
   localparam logic [15:0] A_PULL = 16'hFF73;

   localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_PU = 3, K_SEL = 4;

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      req;
   } item_t;

   logic        clk = 0;
   logic        por_n = 0, hw_stby = 0, man_rst_n = 1, sw_stby = 0;
   logic [2:0]  mode = 3'd3;
   logic [15:0] bus_addr = '0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [7:0]  bus_wdata = '0, pin_in = '0;
   logic [7:0]  bus_rdata, pin_oe, pin_out, pin_pu;
   logic        bus_sel;

   int    total = 0, bad = 0;
   bit    done = 0;
   item_t sb[$];

   always #4 clk = ~clk;

   gpio_mode_port dut (
      .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .man_rst_n(man_rst_n),
      .sw_stby(sw_stby), .mode(mode), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
      .bus_sel(bus_sel)
   );

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
               K_RD:    act = bus_rdata;
               K_OE:    act = pin_oe;
               K_OUT:   act = pin_out;
               K_PU:    act = pin_pu;
               default: act = {7'd0, bus_sel};
            endcase
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic push(int kind, logic [7:0] exp, string req);
      item_t it;
      it.kind = kind; it.exp = exp; it.req = req;
      sb.push_back(it);
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd_exp(logic [15:0] a, logic [7:0] exp, string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1;
      push(K_RD, exp, req);
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic port_exp(int kind, logic [7:0] exp, string req);
      @(negedge clk);
      push(kind, exp, req);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1;
      // R1 reset state
      port_exp(K_OE, 8'h00, "R1");
      port_exp(K_PU, 8'h00, "R1");
      rd_exp(A_DATA, 8'h00, "R1");
      rd_exp(A_PULL, 8'h00, "R1");

      // R9 writes, R5/R7 port mode outputs
      wr(A_DIR,  8'h0F);
      port_exp(K_OE, 8'h0F, "R9");
      wr(A_DATA, 8'hA5);
      wr(A_PULL, 8'hFF);
      port_exp(K_OE,  8'h0F, "R5");
      port_exp(K_OUT, 8'h05, "R5");
      port_exp(K_SEL, 8'h00, "R5");
      port_exp(K_PU,  8'hF0, "R7");
      rd_exp(A_DATA, 8'hA5, "R4");
      rd_exp(A_PULL, 8'hFF, "R4");

      // R8 pin view latency
      @(negedge clk);
      pin_in = 8'h3C;
      @(posedge clk);
      rd_exp(A_PIN, 8'h05, "R8");
      rd_exp(A_PIN, 8'h35, "R8");

      // R9 write to pin view ignored
      wr(A_PIN, 8'hFF);
      rd_exp(A_DATA, 8'hA5, "R9");
      rd_exp(A_PULL, 8'hFF, "R9");
      port_exp(K_OE, 8'h0F, "R9");

      // R4 unmapped address
      wr(16'h1234, 8'h77);
      rd_exp(16'h1234, 8'h00, "R4");
      rd_exp(A_DATA, 8'hA5, "R4");
      port_exp(K_RD, 8'h00, "R4");

      // R6 bus mode
      @(negedge clk); mode = 3'd2;
      port_exp(K_OE,  8'h00, "R6");
      port_exp(K_OUT, 8'h00, "R6");
      port_exp(K_PU,  8'h00, "R6");
      port_exp(K_SEL, 8'h01, "R6");
      rd_exp(A_PIN, 8'h3C, "R8");
      @(negedge clk); mode = 3'd0;
      port_exp(K_SEL, 8'h01, "R6");
      @(negedge clk); mode = 3'd7;
      port_exp(K_OE,  8'h0F, "R5");
      port_exp(K_SEL, 8'h00, "R5");

      // R3 manual reset
      @(negedge clk); man_rst_n = 0;
      wr(A_DATA, 8'h11);
      wr(A_DIR, 8'hFF);
      @(negedge clk); man_rst_n = 1;
      rd_exp(A_DATA, 8'hA5, "R3");
      port_exp(K_OE, 8'h0F, "R3");

      // R3 software standby
      @(negedge clk); sw_stby = 1;
      wr(A_DIR, 8'hFF);
      wr(A_PULL, 8'h00);
      @(negedge clk); sw_stby = 0;
      port_exp(K_OE, 8'h0F, "R3");
      rd_exp(A_PULL, 8'hFF, "R3");

      // R2 hardware standby
      @(negedge clk); hw_stby = 1;
      #1;
      push(K_OE, 8'h00, "R2");
      @(negedge clk); hw_stby = 0;
      rd_exp(A_DATA, 8'h00, "R2");
      rd_exp(A_PULL, 8'h00, "R2");
      port_exp(K_OE, 8'h00, "R2");

      // R1 power-on reset after writes
      wr(A_DIR, 8'hC3);
      wr(A_DATA, 8'h99);
      @(negedge clk); por_n = 0;
      @(negedge clk); por_n = 1;
      port_exp(K_OE, 8'h00, "R1");
      rd_exp(A_DATA, 8'h00, "R1");

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule